// File: doc/BRIEF.md
# Hashed Frame-Table Address Translator

This block translates a virtual page, qualified by the process that owns it, into a physical address. It uses a table that has one entry per physical frame. A request carries a process ID, a virtual page number and a page offset. The engine hashes the process ID and page number into a bucket of an anchor RAM. The anchor gives the first candidate entry in a frame RAM. Each frame entry stores an owner process ID, a virtual page number, a valid flag and a link to the next candidate in the same bucket.

The walker reads candidates one at a time until one matches. It then returns the index of the matching entry as the frame number, joined with the untouched page offset. If the walk meets an empty anchor, an empty link or the chain-length limit, it returns a page fault instead. The size of the table follows the number of physical frames, not the size of the virtual space.

Requests and responses use valid/ready handshakes. Write ports load both RAMs.

Top module: `ipt_lookup`

## Requirements
- R1: `req_ready_o` is high only while the engine is idle. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high. After that edge `req_ready_o` stays low until the response has been taken.
- R2: The bucket is computed from key = zero-extended VPN XOR zero-extended PID. Bit i of the key is XORed into bucket bit (i mod HAT_W).
- R3: A lookup hits on the first entry in the chain whose valid flag is 1 and whose stored PID and stored VPN both equal the request. The response then has `resp_fault_o`=0 and `resp_paddr_o` = {entry index, request offset}.
- R4: When a candidate does not match, the next candidate is the entry named in its link field.
- R5: The null index is the all-ones value of FRAME_W bits. A null anchor gives a fault, and `resp_valid_o` rises one cycle after the accepting edge.
- R6: A non-matching candidate with a null link ends the lookup with a fault.
- R7: If FRAMES candidates have been compared without a hit, the lookup faults. This also applies to a cyclic chain.
- R8: A lookup that ends at chain position k (head is k=0) raises `resp_valid_o` exactly 3+2k cycles after the accepting edge.
- R9: While `resp_valid_o` is high and `resp_ready_i` is low, `resp_valid_o`, `resp_fault_o` and `resp_paddr_o` hold their values.
- R10: After reset `req_ready_o` is 1 and `resp_valid_o` is 0.
- R11: An entry whose valid flag is 0 never hits, even when its tags match. Its link is still followed.
- R12: On a fault `resp_paddr_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine idle and able to take a request |
| req_pid_i | input | PID_W | Requesting process ID |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_off_i | input | OFF_W | Page offset |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response taken |
| resp_fault_o | output | 1 | Page fault |
| resp_paddr_o | output | FRAME_W+OFF_W | Physical address {frame, offset} |
| hat_we_i | input | 1 | Anchor RAM write enable |
| hat_waddr_i | input | HAT_W | Anchor RAM write bucket |
| hat_wdata_i | input | FRAME_W | Anchor head index (all ones = empty) |
| ft_we_i | input | 1 | Frame RAM write enable |
| ft_waddr_i | input | FRAME_W | Frame RAM write index |
| ft_wvalid_i | input | 1 | Entry valid flag |
| ft_wpid_i | input | PID_W | Entry owner PID |
| ft_wvpn_i | input | VPN_W | Entry virtual page number |
| ft_wnext_i | input | FRAME_W | Entry link (all ones = end of chain) |

## Verification
The bench uses the default parameters: 4-bit PID, 8-bit VPN, 4-bit offset, 16 frames and 8 anchor buckets.

With only 8 buckets, it is easy to build colliding keys. These give chains of two and three entries, which exercise process-ID mismatch, invalid entries in the middle of a chain and null-link faults. With 16 frames, a two-entry cyclic chain reaches the compare limit in 33 cycles, so the guard against an endless walk is checked directly.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ANCHOR,
    ST_READ,
    ST_COMPARE,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ipt_ram.sv
module ipt_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int PID_W = 4,
  parameter int VPN_W = 8,
  parameter int HAT_W = 3
) (
  input  logic [PID_W-1:0] pid_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [HAT_W-1:0] bucket_o
);
  localparam int KEY_W = (VPN_W > PID_W) ? VPN_W : PID_W;

  logic [KEY_W-1:0] key;

  assign key = KEY_W'(vpn_i) ^ KEY_W'(pid_i);

  // fold key bit i onto bucket bit i mod HAT_W
  always_comb begin
    bucket_o = '0;
    for (int i = 0; i < KEY_W; i++) begin
      bucket_o[i % HAT_W] = bucket_o[i % HAT_W] ^ key[i];
    end
  end
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
#(
  parameter int PID_W   = 4,
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 4,
  localparam int ENT_W  = 1 + PID_W + VPN_W + FRAME_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [FRAME_W-1:0] hat_rdata_i,
  output logic [FRAME_W-1:0] ft_raddr_o,
  input  logic [ENT_W-1:0]   ft_rdata_i,
  output logic               resp_valid_o,
  input  logic               resp_ready_i,
  output logic               resp_fault_o,
  output logic [PA_W-1:0]    resp_paddr_o
);
  localparam int FRAMES = 1 << FRAME_W;
  localparam int CNT_W  = FRAME_W + 1;
  localparam logic [FRAME_W-1:0] NULL_IDX = '1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(FRAMES - 1);

  walk_state_e        state_q;
  logic [PID_W-1:0]   pid_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [FRAME_W-1:0] idx_q;
  logic [CNT_W-1:0]   steps_q;
  logic               fault_q;

  // entry layout: {valid, pid, vpn, next}
  logic               e_valid;
  logic [PID_W-1:0]   e_pid;
  logic [VPN_W-1:0]   e_vpn;
  logic [FRAME_W-1:0] e_next;
  logic               e_hit;

  assign {e_valid, e_pid, e_vpn, e_next} = ft_rdata_i;
  assign e_hit = e_valid && (e_pid == pid_q) && (e_vpn == vpn_q);

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = (state_q == ST_DONE);
  assign resp_fault_o = fault_q;
  assign resp_paddr_o = fault_q ? '0 : {idx_q, off_q};
  assign ft_raddr_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pid_q   <= '0;
      vpn_q   <= '0;
      off_q   <= '0;
      idx_q   <= '0;
      steps_q <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            pid_q   <= req_pid_i;
            vpn_q   <= req_vpn_i;
            off_q   <= req_off_i;
            state_q <= ST_ANCHOR;
          end
        end
        ST_ANCHOR: begin
          steps_q <= '0;
          if (hat_rdata_i == NULL_IDX) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            idx_q   <= hat_rdata_i;
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_COMPARE;
        ST_COMPARE: begin
          if (e_hit) begin
            fault_q <= 1'b0;
            state_q <= ST_DONE;
          end else if (e_next == NULL_IDX || steps_q == LAST_STEP) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            idx_q   <= e_next;
            steps_q <= steps_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_DONE: begin
          if (resp_ready_i) begin
            fault_q <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int PID_W   = 4,
  parameter int VPN_W   = 8,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 4,
  parameter int HAT_W   = 3,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [PID_W-1:0]   req_pid_i,
  input  logic [VPN_W-1:0]   req_vpn_i,
  input  logic [OFF_W-1:0]   req_off_i,
  output logic               resp_valid_o,
  input  logic               resp_ready_i,
  output logic               resp_fault_o,
  output logic [PA_W-1:0]    resp_paddr_o,
  input  logic               hat_we_i,
  input  logic [HAT_W-1:0]   hat_waddr_i,
  input  logic [FRAME_W-1:0] hat_wdata_i,
  input  logic               ft_we_i,
  input  logic [FRAME_W-1:0] ft_waddr_i,
  input  logic               ft_wvalid_i,
  input  logic [PID_W-1:0]   ft_wpid_i,
  input  logic [VPN_W-1:0]   ft_wvpn_i,
  input  logic [FRAME_W-1:0] ft_wnext_i
);
  localparam int ENT_W = 1 + PID_W + VPN_W + FRAME_W;

  logic [HAT_W-1:0]   bucket;
  logic [FRAME_W-1:0] hat_rdata;
  logic [FRAME_W-1:0] ft_raddr;
  logic [ENT_W-1:0]   ft_rdata;

  ipt_hash #(.PID_W(PID_W), .VPN_W(VPN_W), .HAT_W(HAT_W)) u_hash (
    .pid_i   (req_pid_i),
    .vpn_i   (req_vpn_i),
    .bucket_o(bucket)
  );

  ipt_ram #(.DW(FRAME_W), .AW(HAT_W)) u_anchor_ram (
    .clk_i  (clk_i),
    .we_i   (hat_we_i),
    .waddr_i(hat_waddr_i),
    .wdata_i(hat_wdata_i),
    .raddr_i(bucket),
    .rdata_o(hat_rdata)
  );

  ipt_ram #(.DW(ENT_W), .AW(FRAME_W)) u_frame_ram (
    .clk_i  (clk_i),
    .we_i   (ft_we_i),
    .waddr_i(ft_waddr_i),
    .wdata_i({ft_wvalid_i, ft_wpid_i, ft_wvpn_i, ft_wnext_i}),
    .raddr_i(ft_raddr),
    .rdata_o(ft_rdata)
  );

  ipt_walker #(
    .PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_pid_i   (req_pid_i),
    .req_vpn_i   (req_vpn_i),
    .req_off_i   (req_off_i),
    .hat_rdata_i (hat_rdata),
    .ft_raddr_o  (ft_raddr),
    .ft_rdata_i  (ft_rdata),
    .resp_valid_o(resp_valid_o),
    .resp_ready_i(resp_ready_i),
    .resp_fault_o(resp_fault_o),
    .resp_paddr_o(resp_paddr_o)
  );
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 4,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [OFF_W-1:0] req_off_i,
  input logic             resp_valid_o,
  input logic             resp_ready_i,
  input logic             resp_fault_o,
  input logic [PA_W-1:0]  resp_paddr_o
);
  localparam int FRAMES = 1 << FRAME_W;
  localparam logic [FRAME_W-1:0] NULL_IDX = '1;

  logic [OFF_W-1:0] off_seen_q;
  logic [15:0]      busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_seen_q <= '0;
      busy_cnt_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      off_seen_q <= req_off_i;
      busy_cnt_q <= '0;
    end else if (!req_ready_o && !resp_valid_o) begin
      busy_cnt_q <= busy_cnt_q + 16'd1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !resp_valid_o);

  p_accept_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_resp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_ready_i) |=>
      (resp_valid_o && $stable(resp_fault_o) && $stable(resp_paddr_o)));

  p_offset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_paddr_o[OFF_W-1:0] == off_seen_q));

  p_hit_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_fault_o) |-> (resp_paddr_o[PA_W-1:OFF_W] != NULL_IDX));

  p_fault_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0));

  p_walk_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt_q <= 16'(2 * FRAMES + 1));
endmodule

bind ipt_lookup ipt_lookup_chk #(.OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_off_i   (req_off_i),
  .resp_valid_o(resp_valid_o),
  .resp_ready_i(resp_ready_i),
  .resp_fault_o(resp_fault_o),
  .resp_paddr_o(resp_paddr_o)
);

// File: tb/ipt_lookup_tb.sv
`timescale 1ns/1ps
module ipt_lookup_tb;
  localparam int PID_W = 4, VPN_W = 8, OFF_W = 4, FRAME_W = 4, HAT_W = 3;
  localparam int FRAMES = 1 << FRAME_W;
  localparam int HAT_N  = 1 << HAT_W;
  localparam int PA_W   = FRAME_W + OFF_W;
  localparam logic [FRAME_W-1:0] NUL = '1;

  logic clk_i = 0, rst_ni = 0;
  logic req_valid_i = 0, resp_ready_i = 0;
  logic [PID_W-1:0] req_pid_i = '0;
  logic [VPN_W-1:0] req_vpn_i = '0;
  logic [OFF_W-1:0] req_off_i = '0;
  logic req_ready_o, resp_valid_o, resp_fault_o;
  logic [PA_W-1:0] resp_paddr_o;
  logic hat_we_i = 0;
  logic [HAT_W-1:0] hat_waddr_i = '0;
  logic [FRAME_W-1:0] hat_wdata_i = '0;
  logic ft_we_i = 0, ft_wvalid_i = 0;
  logic [FRAME_W-1:0] ft_waddr_i = '0, ft_wnext_i = '0;
  logic [PID_W-1:0] ft_wpid_i = '0;
  logic [VPN_W-1:0] ft_wvpn_i = '0;

  ipt_lookup #(.PID_W(PID_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W),
               .HAT_W(HAT_W)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench-side table model
  logic [FRAME_W-1:0] m_hat [HAT_N];
  logic               m_val [FRAMES];
  logic [PID_W-1:0]   m_pid [FRAMES];
  logic [VPN_W-1:0]   m_vpn [FRAMES];
  logic [FRAME_W-1:0] m_nxt [FRAMES];

  typedef struct {bit fault; logic [PA_W-1:0] paddr; int lat; int acc; string req;} exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // R2: fold (vpn ^ pid) bit i onto bucket bit i mod HAT_W
  function automatic logic [HAT_W-1:0] bucket_of(input logic [PID_W-1:0] p,
                                                  input logic [VPN_W-1:0] v);
    logic [VPN_W-1:0] k = v ^ VPN_W'(p);
    logic [HAT_W-1:0] b = '0;
    for (int i = 0; i < VPN_W; i++) b[i % HAT_W] ^= k[i];
    return b;
  endfunction

  task automatic set_hat(input logic [HAT_W-1:0] a, input logic [FRAME_W-1:0] d);
    @(negedge clk_i);
    hat_we_i = 1; hat_waddr_i = a; hat_wdata_i = d;
    @(negedge clk_i);
    hat_we_i = 0;
    m_hat[a] = d;
  endtask

  task automatic set_ft(input logic [FRAME_W-1:0] a, input logic v,
                        input logic [PID_W-1:0] p, input logic [VPN_W-1:0] vp,
                        input logic [FRAME_W-1:0] n);
    @(negedge clk_i);
    ft_we_i = 1; ft_waddr_i = a; ft_wvalid_i = v; ft_wpid_i = p;
    ft_wvpn_i = vp; ft_wnext_i = n;
    @(negedge clk_i);
    ft_we_i = 0;
    m_val[a] = v; m_pid[a] = p; m_vpn[a] = vp; m_nxt[a] = n;
  endtask

  // driver: predicts per R3..R8, R11, R12 and pushes into scoreboard
  task automatic lookup(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                        input logic [OFF_W-1:0] o, input string req);
    exp_t e;
    logic [FRAME_W-1:0] idx;
    bit fin;
    e.req = req; e.fault = 1; e.paddr = '0;
    idx = m_hat[bucket_of(p, v)];
    fin = 0;
    if (idx == NUL) begin
      e.lat = 1;
    end else begin
      e.lat = 3 + 2 * (FRAMES - 1);
      for (int k = 0; k < FRAMES; k++) begin
        if (!fin) begin
          if (m_val[idx] && m_pid[idx] == p && m_vpn[idx] == v) begin
            e.fault = 0; e.paddr = {idx, o}; e.lat = 3 + 2 * k; fin = 1;
          end else if (m_nxt[idx] == NUL) begin
            e.lat = 3 + 2 * k; fin = 1;
          end else begin
            idx = m_nxt[idx];
          end
        end
      end
    end
    @(negedge clk_i);
    req_valid_i = 1; req_pid_i = p; req_vpn_i = v; req_off_i = o;
    while (!req_ready_o) @(negedge clk_i);
    e.acc = cyc + 1;
    sb.push_back(e);
    @(negedge clk_i);
    req_valid_i = 0;
    check(req_ready_o == 1'b0, "R1", "ready after accept", int'(req_ready_o), 0);
    while (sb.size() != 0 || resp_valid_o) @(negedge clk_i);
  endtask

  // monitor: pops and compares, stalls every third response (R9)
  int n_resp = 0, stall = 0;
  logic [PA_W-1:0] held_pa;
  logic held_f;
  bit seen = 0;
  initial begin
    forever begin
      @(negedge clk_i);
      if (seen && resp_ready_i) begin
        resp_ready_i = 0; seen = 0;
      end else if (seen) begin
        check(resp_valid_o && resp_fault_o == held_f && resp_paddr_o == held_pa,
              "R9", "held response", int'(resp_paddr_o), int'(held_pa));
        stall--;
        if (stall == 0) resp_ready_i = 1;
      end else if (rst_ni && resp_valid_o) begin
        exp_t e;
        seen = 1;
        if (sb.size() == 0) begin
          check(0, "R1", "unexpected response", 1, 0);
        end else begin
          e = sb.pop_front();
          check(resp_fault_o == e.fault, e.req, "fault", int'(resp_fault_o), int'(e.fault));
          check(resp_paddr_o == e.paddr, e.req, "paddr", int'(resp_paddr_o), int'(e.paddr));
          check(cyc - e.acc == e.lat, "R8", {e.req, " latency"}, cyc - e.acc, e.lat);
        end
        n_resp++;
        held_pa = resp_paddr_o; held_f = resp_fault_o;
        stall = (n_resp % 3 == 0) ? 2 : 0;
        if (stall == 0) resp_ready_i = 1;
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [HAT_W-1:0] b;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(req_ready_o == 1, "R10", "ready in reset", int'(req_ready_o), 1);
    check(resp_valid_o == 0, "R10", "resp_valid in reset", int'(resp_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(req_ready_o == 1 && resp_valid_o == 0, "R10", "idle after reset",
          int'({req_ready_o, resp_valid_o}), 2);

    for (int i = 0; i < HAT_N; i++) set_hat(HAT_W'(i), NUL);
    for (int i = 0; i < FRAMES; i++) set_ft(FRAME_W'(i), 0, '0, '0, NUL);

    // R5: empty anchor
    lookup(4'h3, 8'h21, 4'hA, "R5");

    // R2/R3: single entry at frame 5
    b = bucket_of(4'h3, 8'h21);
    set_hat(b, 4'd5);
    set_ft(4'd5, 1, 4'h3, 8'h21, NUL);
    lookup(4'h3, 8'h21, 4'hA, "R3");
    lookup(4'h3, 8'h21, 4'h4, "R2");

    // R4: collision (pid 2, vpn 0x20) has the same key, frame 9 chained after 5
    set_ft(4'd5, 1, 4'h3, 8'h21, 4'd9);
    set_ft(4'd9, 1, 4'h2, 8'h20, NUL);
    lookup(4'h2, 8'h20, 4'h7, "R4");
    lookup(4'h3, 8'h21, 4'h1, "R3");

    // R6: same bucket, no matching entry, chain ends after two
    lookup(4'h1, 8'h23, 4'h2, "R6");

    // R11: matching tags but invalid at frame 7 (position 2)
    set_ft(4'd9, 1, 4'h2, 8'h20, 4'd7);
    set_ft(4'd7, 0, 4'h1, 8'h23, NUL);
    lookup(4'h1, 8'h23, 4'h2, "R11");
    set_ft(4'd7, 1, 4'h1, 8'h23, NUL);
    lookup(4'h1, 8'h23, 4'hF, "R11");

    // R3: pid mismatch alone must not hit (same vpn, other pid -> other bucket here)
    lookup(4'h0, 8'h21, 4'h3, "R3");

    // R7: cyclic chain 10 -> 11 -> 10 with no match
    b = bucket_of(4'h0, 8'h55);
    set_hat(b, 4'd10);
    set_ft(4'd10, 1, 4'h0, 8'h01, 4'd11);
    set_ft(4'd11, 1, 4'h0, 8'h02, 4'd10);
    lookup(4'h0, 8'h55, 4'h6, "R7");

    // R12 and mixed traffic
    for (int i = 0; i < 24; i++) begin
      logic [PID_W-1:0] p = PID_W'($urandom_range(0, 3));
      logic [VPN_W-1:0] v = (i % 2 == 0) ? VPN_W'($urandom) : VPN_W'(8'h20 + (i % 4));
      lookup(p, v, OFF_W'($urandom), "R12");
    end

    repeat (4) @(negedge clk_i);
    check(sb.size() == 0, "R1", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule